// File: doc/BRIEF.md
# Amplifier Fault Protection Manager

This block sits between the analog fault monitors of a two-channel switching audio amplifier and its power-stage drivers. Every cycle it looks at a set of one-bit fault flags and decides how the output stage reacts. The flags cover temperature, output current, supply level, supply balance and a rail-short check. The reaction depends on the fault class. A warm die only asks for less gain. A current overload into a normal load keeps the outputs switching while the current is held at its limit. Hard faults stop the power stage and start a retry timer that counts a millisecond tick. A rail-short check failure stops the power stage until the check passes, with no timer.

The shutdown-class faults are over-temperature, overvoltage, undervoltage, supply unbalance, and an overcurrent caused by a low-impedance short. When the retry timer runs out, the manager restarts only if all of these flags are low at that moment. If any is still high, it loads the timer again. A restart that follows a short-circuit shutdown first passes through a one-cycle rail-short check. A cause code reports the most serious active fault, or the fault that caused the current shutdown. A diagnostic flag reports overcurrent events and no other fault class. All pins are plain control and status levels. No data flows through the block, so it has no valid/ready interface and no back-pressure.

Top module: `amp_fault_mgr`

## Requirements
- R1: While `tfold_i` is high, `gain_cut_o` is high and the stage stays enabled with cause code 0 (no other fault active).
- R2: `otemp_i` high disables the power stage in the same cycle and reports cause code 1. Once the flag has cleared, switching resumes when the 100-tick retry period expires.
- R3: `ocur_i` high with `oshort_i` low does not shut down the stage: `stage_en_o` stays high and the cause code stays 0.
- R4: `ocur_i` and `oshort_i` high together shut down the stage and report cause code 5. While the short persists, a new 100-tick period starts at each expiry and the stage stays off. The stage resumes at the first expiry after the short is gone.
- R5: `uvolt_i` (cause 3), `ovolt_i` (cause 2) and `unbal_i` (cause 4) each shut down the stage. It restarts about 100 ticks after the shutdown once the flag has cleared.
- R6: `wchk_i` high disables the stage in the same cycle with cause code 6, without the retry timer. The stage re-enables in the cycle after `wchk_i` falls.
- R7: When the retry period after a short-circuit shutdown expires, a high `wchk_i` keeps the stage off with cause 6 until `wchk_i` falls.
- R8: `diag_o` is high while `ocur_i` is high. It also stays high from a short-circuit shutdown until switching resumes. It never rises for any other fault class.
- R9: With several faults active, the cause code is that of the highest-priority one, in the order over-temperature (1), overvoltage (2), undervoltage (3), unbalance (4), short (5), window (6). While the stage waits with no fault active, the last reported cause is held.
- R10: `stage_en_o` is low in the very cycle any shutdown-class flag is first high.
- R11: A shutdown-class flag that is still high when the retry period expires reloads the timer, so the stage stays off for another full 100 ticks.
- R12: After reset with no faults, `stage_en_o` is high and `gain_cut_o`, `diag_o` and `cause_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick_i | input | 1 | One-cycle pulse per millisecond |
| tfold_i | input | 1 | Die temperature in foldback range |
| otemp_i | input | 1 | Die temperature above shutdown limit |
| ocur_i | input | 1 | Output current at limit |
| oshort_i | input | 1 | Overload is a low-impedance short |
| uvolt_i | input | 1 | Supply below minimum |
| ovolt_i | input | 1 | Supply above maximum |
| unbal_i | input | 1 | Positive and negative supplies unbalanced |
| wchk_i | input | 1 | Output shorted to a rail (start-up check) |
| stage_en_o | output | 1 | Power stage switching enable |
| gain_cut_o | output | 1 | Request 6 dB gain reduction |
| diag_o | output | 1 | Overcurrent diagnostic |
| cause_o | output | 3 | Shutdown cause code (see R9) |

## Verification
The hardest state to reach from the ports is the rail-short check that follows a short-circuit retry. A short has to cause a shutdown and then clear. The window fault then has to be raised after that, while the timer is still counting, so that it is present in the single cycle where the expired timer hands over to the check. The bench gets there by counting millisecond ticks at the ports. It raises the window flag about ninety ticks into the period and observes the stage well past the expiry. Retry timing is checked by counting the ticks seen while the stage is off and comparing the count against one or more whole periods.

// File: rtl/ampprot_pkg.sv
package ampprot_pkg;
  typedef enum logic [2:0] {
    CZ_NONE   = 3'd0,
    CZ_HOT    = 3'd1,
    CZ_OVERV  = 3'd2,
    CZ_UNDERV = 3'd3,
    CZ_UNBAL  = 3'd4,
    CZ_SHORT  = 3'd5,
    CZ_WINDOW = 3'd6
  } cause_e;

  typedef enum logic [1:0] {
    PS_RUN,
    PS_HOLD,
    PS_RAILCHK,
    PS_WINWAIT
  } pstate_e;

  localparam int unsigned N_CLASSES = 6;
endpackage

// File: rtl/fault_rank.sv
module fault_rank
  import ampprot_pkg::*;
(
  input  logic   otemp_i,
  input  logic   ovolt_i,
  input  logic   uvolt_i,
  input  logic   unbal_i,
  input  logic   short_i,
  input  logic   wchk_i,
  output logic   any_sd_o,
  output logic   active_o,
  output cause_e top_o
);
  // index 0 is the most serious class
  logic [N_CLASSES-1:0] vec;
  assign vec = {wchk_i, short_i, unbal_i, uvolt_i, ovolt_i, otemp_i};

  always_comb begin
    top_o = CZ_NONE;
    for (int i = N_CLASSES - 1; i >= 0; i--) begin
      if (vec[i]) top_o = cause_e'(3'(i + 1));
    end
  end

  assign any_sd_o = |vec[N_CLASSES-2:0];
  assign active_o = |vec;
endmodule

// File: rtl/retry_timer.sv
module retry_timer #(
  parameter int unsigned RETRY_MS = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic tick_i,
  output logic expired_o
);
  localparam int unsigned CW = $clog2(RETRY_MS + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(RETRY_MS);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                  cnt <= '0;
    else if (load_i)             cnt <= LOAD_VAL;
    else if (tick_i && cnt != 0) cnt <= cnt - 1'b1;
  end

  assign expired_o = (cnt == '0);

  // R11
  timer_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LOAD_VAL);

  // R11
  timer_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> !expired_o);
endmodule

// File: rtl/prot_seq.sv
module prot_seq
  import ampprot_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   any_sd_i,
  input  logic   active_i,
  input  logic   wchk_i,
  input  logic   short_i,
  input  logic   ocur_i,
  input  cause_e top_i,
  input  logic   expired_i,
  output logic   load_o,
  output logic   stage_en_o,
  output logic   diag_o,
  output cause_e cause_o
);
  pstate_e st, nxt;
  logic    oc_q;
  cause_e  cause_q;

  always_comb begin
    nxt    = st;
    load_o = 1'b0;
    unique case (st)
      PS_RUN: begin
        if (any_sd_i) begin
          nxt = PS_HOLD; load_o = 1'b1;
        end else if (wchk_i) begin
          nxt = PS_WINWAIT;
        end
      end
      PS_HOLD: begin
        if (expired_i) begin
          if (any_sd_i)  load_o = 1'b1;
          else if (oc_q) nxt = PS_RAILCHK;
          else           nxt = PS_RUN;
        end
      end
      PS_RAILCHK: begin
        if (any_sd_i) begin
          nxt = PS_HOLD; load_o = 1'b1;
        end else if (wchk_i) nxt = PS_WINWAIT;
        else                 nxt = PS_RUN;
      end
      PS_WINWAIT: begin
        if (any_sd_i) begin
          nxt = PS_HOLD; load_o = 1'b1;
        end else if (!wchk_i) nxt = PS_RUN;
      end
      default: nxt = PS_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= PS_RUN;
      oc_q    <= 1'b0;
      cause_q <= CZ_NONE;
    end else begin
      st <= nxt;
      if (nxt == PS_RUN) oc_q <= 1'b0;
      else if (short_i)  oc_q <= 1'b1;
      if (active_i)          cause_q <= top_i;
      else if (st == PS_RUN) cause_q <= CZ_NONE;
    end
  end

  assign stage_en_o = (st == PS_RUN) && !any_sd_i && !wchk_i;
  assign diag_o     = ocur_i || oc_q;
  assign cause_o    = active_i ? top_i : ((st == PS_RUN) ? CZ_NONE : cause_q);

  // R10
  en_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_sd_i |-> !stage_en_o);

  // R6
  win_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PS_WINWAIT && !wchk_i && !any_sd_i) |=> st == PS_RUN);

  // R11
  hold_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PS_HOLD && expired_i && any_sd_i) |=> (st == PS_HOLD && !expired_i));

  // R7
  railchk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PS_RAILCHK && wchk_i && !any_sd_i) |=> st == PS_WINWAIT);

  // R9
  cause_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != PS_RUN) |-> cause_o != CZ_NONE);

  // R8
  diag_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (diag_o && !ocur_i) |-> !stage_en_o);
endmodule

// File: rtl/amp_fault_mgr.sv
module amp_fault_mgr
  import ampprot_pkg::*;
#(
  parameter int unsigned RETRY_MS = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ms_tick_i,
  input  logic       tfold_i,
  input  logic       otemp_i,
  input  logic       ocur_i,
  input  logic       oshort_i,
  input  logic       uvolt_i,
  input  logic       ovolt_i,
  input  logic       unbal_i,
  input  logic       wchk_i,
  output logic       stage_en_o,
  output logic       gain_cut_o,
  output logic       diag_o,
  output logic [2:0] cause_o
);
  logic   short_w, any_sd, active, t_load, t_exp;
  cause_e top_c, cause_c;

  assign short_w = ocur_i && oshort_i;

  fault_rank u_rank (
    .otemp_i (otemp_i),
    .ovolt_i (ovolt_i),
    .uvolt_i (uvolt_i),
    .unbal_i (unbal_i),
    .short_i (short_w),
    .wchk_i  (wchk_i),
    .any_sd_o(any_sd),
    .active_o(active),
    .top_o   (top_c)
  );

  retry_timer #(.RETRY_MS(RETRY_MS)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (t_load),
    .tick_i   (ms_tick_i),
    .expired_o(t_exp)
  );

  prot_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .any_sd_i  (any_sd),
    .active_i  (active),
    .wchk_i    (wchk_i),
    .short_i   (short_w),
    .ocur_i    (ocur_i),
    .top_i     (top_c),
    .expired_i (t_exp),
    .load_o    (t_load),
    .stage_en_o(stage_en_o),
    .diag_o    (diag_o),
    .cause_o   (cause_c)
  );

  assign cause_o    = cause_c;
  assign gain_cut_o = tfold_i;

  // R2
  hot_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    otemp_i |-> (!stage_en_o && cause_o == 3'd1));

  // R3
  clip_keeps_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_en_o && ocur_i && !oshort_i && !otemp_i && !uvolt_i && !ovolt_i
      && !unbal_i && !wchk_i) |=> (stage_en_o || $changed(ocur_i) || $changed(oshort_i)
      || otemp_i || uvolt_i || ovolt_i || unbal_i || wchk_i));
endmodule

// File: tb/amp_fault_mgr_bench.sv
module amp_fault_mgr_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ms_tick = 1'b0;
  logic tfold = 0, otemp = 0, ocur = 0, oshort = 0, uvolt = 0, ovolt = 0, unbal = 0, wchk = 0;
  logic stage_en, gain_cut, diag;
  logic [2:0] cause;

  always #10 clk = ~clk;

  amp_fault_mgr u_amp_fault_mgr (
    .clk(clk), .rst_n(rst_n), .ms_tick_i(ms_tick),
    .tfold_i(tfold), .otemp_i(otemp), .ocur_i(ocur), .oshort_i(oshort),
    .uvolt_i(uvolt), .ovolt_i(ovolt), .unbal_i(unbal), .wchk_i(wchk),
    .stage_en_o(stage_en), .gain_cut_o(gain_cut), .diag_o(diag), .cause_o(cause)
  );

  int tick_div = 0;
  always @(posedge clk) begin
    tick_div <= (tick_div == 4) ? 0 : tick_div + 1;
    ms_tick  <= (tick_div == 4);
  end

  int low_ticks = 0;
  always @(negedge clk) if (rst_n && !stage_en && ms_tick) low_ticks <= low_ticks + 1;

  typedef struct {
    logic en, gain, dg;
    logic [2:0] cz;
    string req;
  } exp_t;
  exp_t sb[$];
  exp_t cur;
  int checks = 0, fails = 0;

  always @(negedge clk) begin
    if (sb.size() > 0) begin
      cur = sb.pop_front();
      checks++;
      if (stage_en !== cur.en || gain_cut !== cur.gain || diag !== cur.dg || cause !== cur.cz) begin
        fails++;
        $display("FAIL %s: got en=%b gain=%b diag=%b cause=%0d, expected en=%b gain=%b diag=%b cause=%0d",
                 cur.req, stage_en, gain_cut, diag, cause, cur.en, cur.gain, cur.dg, cur.cz);
      end
    end
  end

  task automatic set_in(input logic t, o, oc, sh, uv, ov, ub, w);
    @(posedge clk); #2;
    tfold = t; otemp = o; ocur = oc; oshort = sh; uvolt = uv; ovolt = ov; unbal = ub; wchk = w;
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic expect_out(input logic en, gain, dg, input logic [2:0] cz, input string req);
    exp_t e;
    e.en = en; e.gain = gain; e.dg = dg; e.cz = cz; e.req = req;
    sb.push_back(e);
  endtask

  task automatic wait_ticks(input int n);
    int k = 0;
    while (k < n) begin
      @(negedge clk);
      if (ms_tick) k++;
    end
  endtask

  task automatic wait_enable();
    while (!stage_en) @(negedge clk);
  endtask

  task automatic chk_range(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s: got %0d ticks off, expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  int base;

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    step(); expect_out(1, 0, 0, 0, "R12 reset state");

    // R1 foldback
    set_in(1,0,0,0,0,0,0,0); expect_out(1, 1, 0, 0, "R1 foldback");
    set_in(0,0,0,0,0,0,0,0); expect_out(1, 0, 0, 0, "R1 foldback off");

    // R3 clipping only
    set_in(0,0,1,0,0,0,0,0); expect_out(1, 0, 1, 0, "R3 limit no shutdown");
    step(); expect_out(1, 0, 1, 0, "R3 still running, R8 diag");
    set_in(0,0,0,0,0,0,0,0); expect_out(1, 0, 0, 0, "R8 diag follows ocur");

    // R2 / R10 / R9 over-temperature with overvoltage
    wait_ticks(1); @(negedge clk);
    base = low_ticks;
    set_in(0,1,0,0,0,1,0,0); expect_out(0, 0, 0, 1, "R2 R10 immediate off, R8 no diag");
    set_in(0,0,0,0,0,1,0,0); expect_out(0, 0, 0, 2, "R9 overvoltage next");
    set_in(0,0,0,0,0,0,0,0); expect_out(0, 0, 0, 2, "R9 cause held");
    wait_enable();
    chk_range("R2 resume after period", low_ticks - base, 100, 102);
    step(); expect_out(1, 0, 0, 0, "R2 running again");

    // R5 undervoltage brief
    wait_ticks(1); @(negedge clk);
    base = low_ticks;
    set_in(0,0,0,0,1,0,0,0); expect_out(0, 0, 0, 3, "R5 undervoltage");
    wait_ticks(10);
    set_in(0,0,0,0,0,0,0,0); expect_out(0, 0, 0, 3, "R5 waiting");
    wait_enable();
    chk_range("R5 undervoltage restart", low_ticks - base, 100, 102);

    // R11 unbalance held over the expiry
    wait_ticks(1); @(negedge clk);
    base = low_ticks;
    set_in(0,0,0,0,0,0,1,0); expect_out(0, 0, 0, 4, "R5 unbalance");
    wait_ticks(150);
    step(); expect_out(0, 0, 0, 4, "R11 still off after expiry");
    set_in(0,0,0,0,0,0,0,0);
    wait_enable();
    chk_range("R11 reload second period", low_ticks - base, 200, 203);

    // R4 persistent short
    wait_ticks(1); @(negedge clk);
    base = low_ticks;
    set_in(0,0,1,1,0,0,0,0); expect_out(0, 0, 1, 5, "R4 short shutdown");
    wait_ticks(150);
    step(); expect_out(0, 0, 1, 5, "R4 retry fails while short");
    wait_ticks(100);
    set_in(0,0,0,0,0,0,0,0); expect_out(0, 0, 1, 5, "R8 diag held during short wait");
    wait_enable();
    chk_range("R4 restart after short", low_ticks - base, 300, 304);
    step(); expect_out(1, 0, 0, 0, "R8 diag clears on restart");

    // R7 rail check after short retry
    wait_ticks(1);
    set_in(0,0,1,1,0,0,0,0); expect_out(0, 0, 1, 5, "R4 short again");
    wait_ticks(5);
    set_in(0,0,0,0,0,0,0,0);
    wait_ticks(85);
    set_in(0,0,0,0,0,0,0,1); expect_out(0, 0, 1, 6, "R7 window during wait");
    wait_ticks(40);
    step(); expect_out(0, 0, 1, 6, "R7 held by rail check");
    set_in(0,0,0,0,0,0,0,0); expect_out(0, 0, 1, 6, "R6 clear seen");
    step(); expect_out(1, 0, 0, 0, "R6 R7 direct restart");

    // R6 window fault while running
    set_in(0,0,0,0,0,0,0,1); expect_out(0, 0, 0, 6, "R6 window off same cycle");
    step(); step(); expect_out(0, 0, 0, 6, "R6 window hold");
    set_in(0,0,0,0,0,0,0,0); expect_out(0, 0, 0, 6, "R6 window clearing");
    step(); expect_out(1, 0, 0, 0, "R6 restart without timer");

    // R9 priority
    set_in(0,0,1,1,1,0,1,0); expect_out(0, 0, 1, 3, "R9 under over unbal/short");
    set_in(0,0,1,1,1,1,1,1); expect_out(0, 0, 1, 2, "R9 overvoltage wins");
    set_in(0,0,1,1,0,0,0,1); expect_out(0, 0, 1, 5, "R9 short over window");
    set_in(0,0,0,0,0,0,0,0);
    wait_enable();
    step(); expect_out(1, 0, 0, 0, "R9 recovered");
    step();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule